// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds a parameterised set of independent down-counters, 32 bits each, that share one single-cycle register port. Every channel has a reload value, a live count, a control word and a second path that changes the reload value without touching the live count. A channel counts the prescaled `tick` strobes. It can run periodically, expiring and reloading on every period, or in one-shot mode, where it stops at zero. The live count falls as time passes, so software that wants a rising timestamp negates the value it reads.

All channels share a raw interrupt register, a mask register and a write-one-to-clear register, each with one bit per channel. One combined `irq` output goes high while any channel has a pending event that is not masked.

The register port has no back-pressure. An access is a single cycle in which `bus_sel` is high, and the port always accepts it. Read data is valid combinationally in that same cycle. No valid/ready stream appears here, because the block has no data path.

Top module: `multi_timer`

## Requirements
- R1: After reset, every register reads zero, every channel is disabled and `irq` is low.
- R2: Writing a channel's load word at offset 0x10+0x10·n sets both its reload value and its live count. Once enabled, the channel sets its raw bit (bit n of offset 0x04) on exactly the N-th prescaled tick after that write, for any load N ≥ 1.
- R3: A reload value of zero gives the longest period. In a wide-mode channel the count steps from 0 to 0xFFFFFFFF, and a narrow-mode channel expires only on the 65536th tick.
- R4: Control bit 1 selects wide mode when set and narrow mode when clear. In narrow mode loads and decrements keep only the low 16 bits of the count, and the reload word still reads back at its full width.
- R5: In periodic mode (control bit 0 clear) an expiry reloads the count from the reload value. A write to the second reload word at 0x1C+0x10·n changes that value but leaves the live count untouched.
- R6: In one-shot mode (control bit 0 set) the count sets the raw bit and then holds at zero. Only a new load write, or a control write that takes the enable bit (bit 7) from 0 to 1, restarts it; that enable edge reloads the count from the reload value.
- R7: Control bits 3:2 choose the prescaler. The value 00 counts every tick and any other value counts every 16th tick. The prescaler restarts on every load write and on every enable edge.
- R8: While a channel's enable bit is clear its count does not change and ticks have no effect.
- R9: The mask register sits at 0x00 with channel n at bit n. `irq` is the OR over all channels of raw AND mask, and offset 0x08 reads that same AND.
- R10: Writing ones to 0x0C clears the matching raw bits and zero bits have no effect. An expiry in the same cycle as its clear leaves the raw bit set.
- R11: A control write keeps only bits 7 and 3:0, and the control word reads back masked the same way. Writes to the live-count word are ignored. Offset 0x0C reads zero. Unaligned or unmapped accesses read zero and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is the full-length period after a zero load, together with the coincidence of an expiry and its own clear in one cycle. The stimulus reaches the first with a channel in narrow mode, so a zero load runs 65536 ticks and is measured to the exact cycle. It reaches the second by starting a one-shot count of two, giving one tick, and then issuing the clear write in the cycle of the second tick. A behavioural model of all channels is checked against `bus_rdata` and `irq` on every clock.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;

  // control word bit positions
  localparam int CTRL_ONESHOT = 0;
  localparam int CTRL_WIDE    = 1;
  localparam int CTRL_PS_LO   = 2;
  localparam int CTRL_PS_HI   = 3;
  localparam int CTRL_ENABLE  = 7;
  localparam logic [7:0] CTRL_KEEP = 8'h8F;

  // word select inside a channel group
  typedef enum logic [1:0] {
    CH_RELOAD = 2'd0,
    CH_COUNT  = 2'd1,
    CH_CTRL   = 2'd2,
    CH_SHADOW = 2'd3
  } ch_word_e;

  // word select inside the shared group
  typedef enum logic [1:0] {
    SH_MASK   = 2'd0,
    SH_RAW    = 2'd1,
    SH_MASKED = 2'd2,
    SH_CLEAR  = 2'd3
  } sh_word_e;

endpackage

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
module timer_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic slow,
  output logic fire
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign fire = run & tick & (~slow | (phase_q == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run & tick & slow) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  // in slow mode two strobes never come back to back
  AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && slow && !restart) |=> (!fire || !slow)); // R7

endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
module timer_channel
  import timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int PS_DIV   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_we,
  input  logic             sh_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [7:0]       ctrl_o,
  output logic             expire_o
);
  localparam int PAD_W = CNT_W - NARROW_W;

  logic [CNT_W-1:0] count_q, reload_q;
  logic [7:0]       ctrl_q;
  logic             done_q;
  logic             en, oneshot, wide, slow, en_rise, run, fire, at_one;

  function automatic logic [CNT_W-1:0] fit(input logic [CNT_W-1:0] v, input logic w);
    fit = w ? v : {{PAD_W{1'b0}}, v[NARROW_W-1:0]};
  endfunction

  assign en      = ctrl_q[CTRL_ENABLE];
  assign oneshot = ctrl_q[CTRL_ONESHOT];
  assign wide    = ctrl_q[CTRL_WIDE];
  assign slow    = |ctrl_q[CTRL_PS_HI:CTRL_PS_LO];
  assign en_rise = ctl_we & ~en & wdata[CTRL_ENABLE];
  assign run     = en & ~done_q;
  assign at_one  = (count_q == CNT_W'(1));

  timer_prescaler #(.DIV(PS_DIV)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .restart (ld_we | en_rise),
    .slow    (slow),
    .fire    (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      count_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      if (ctl_we) ctrl_q <= wdata[7:0] & CTRL_KEEP;
      if (ld_we | sh_we) reload_q <= wdata;
      if (ld_we) begin
        count_q <= fit(wdata, wide);
        done_q  <= 1'b0;
      end else if (en_rise) begin
        count_q <= fit(reload_q, wdata[CTRL_WIDE]);
        done_q  <= 1'b0;
      end else if (fire) begin
        if (at_one) begin
          if (oneshot) begin
            count_q <= '0;
            done_q  <= 1'b1;
          end else begin
            count_q <= fit(reload_q, wide);
          end
        end else begin
          count_q <= fit(count_q - 1'b1, wide);
        end
      end
    end
  end

  assign expire_o = fire & at_one;
  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld_we && !ctl_we) |=> $stable(count_q)); // R8

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && oneshot && !ld_we && !ctl_we) |=> (count_q == '0)); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ld_we && !ctl_we) |=> $stable(count_q)); // R6

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !oneshot && wide && !ld_we && !ctl_we && !sh_we)
      |=> (count_q == $past(reload_q))); // R5

endmodule

// File: rtl/timer_irq.sv
`timescale 1ns/1ps
module timer_irq #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] raw_o,
  output logic              irq
);
  logic [NUM_CH-1:0] mask_q, raw_q, clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      if (mask_we) mask_q <= wdata;
      raw_q <= (raw_q & ~clr_bits) | expire;
    end
  end

  assign mask_o = mask_q;
  assign raw_o  = raw_q;
  assign irq    = |(raw_q & mask_q);

  AST_EXPIRY_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> ((raw_q & $past(expire)) == $past(expire))); // R10

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !(|expire)) |=> ((raw_q & $past(clr_bits)) == '0)); // R10

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R9

endmodule

// File: rtl/multi_timer.sv
`timescale 1ns/1ps
module multi_timer
  import timer_pkg::*;
#(
  parameter  int NUM_CH   = 2,
  parameter  int CNT_W    = 32,
  parameter  int NARROW_W = 16,
  parameter  int PS_DIV   = 16,
  localparam int ADDR_W   = $clog2(16 * (NUM_CH + 1)),
  localparam int GRP_W    = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [GRP_W-1:0] grp;
  logic [1:0]       word;
  logic             aligned, acc_wr, acc_rd;

  assign grp     = bus_addr[ADDR_W-1:4];
  assign word    = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign acc_wr  = bus_sel & bus_wr & aligned;
  assign acc_rd  = bus_sel & ~bus_wr & aligned;

  logic [CNT_W-1:0]  ch_count  [NUM_CH];
  logic [CNT_W-1:0]  ch_reload [NUM_CH];
  logic [7:0]        ch_ctrl   [NUM_CH];
  logic [NUM_CH-1:0] expire, mask, raw;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = acc_wr & (grp == GRP_W'(c + 1));

    timer_channel #(
      .CNT_W    (CNT_W),
      .NARROW_W (NARROW_W),
      .PS_DIV   (PS_DIV)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ld_we    (hit & (word == CH_RELOAD)),
      .sh_we    (hit & (word == CH_SHADOW)),
      .ctl_we   (hit & (word == CH_CTRL)),
      .wdata    (bus_wdata),
      .count_o  (ch_count[c]),
      .reload_o (ch_reload[c]),
      .ctrl_o   (ch_ctrl[c]),
      .expire_o (expire[c])
    );
  end

  timer_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (acc_wr & (grp == '0) & (word == SH_MASK)),
    .clr_we  (acc_wr & (grp == '0) & (word == SH_CLEAR)),
    .wdata   (bus_wdata[NUM_CH-1:0]),
    .expire  (expire),
    .mask_o  (mask),
    .raw_o   (raw),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc_rd) begin
      if (grp == '0) begin
        case (sh_word_e'(word))
          SH_MASK:   bus_rdata = {{(CNT_W-NUM_CH){1'b0}}, mask};
          SH_RAW:    bus_rdata = {{(CNT_W-NUM_CH){1'b0}}, raw};
          SH_MASKED: bus_rdata = {{(CNT_W-NUM_CH){1'b0}}, raw & mask};
          default:   bus_rdata = '0;
        endcase
      end else begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (grp == GRP_W'(c + 1)) begin
            case (ch_word_e'(word))
              CH_COUNT: bus_rdata = ch_count[c];
              CH_CTRL:  bus_rdata = {{(CNT_W-8){1'b0}}, ch_ctrl[c]};
              default:  bus_rdata = ch_reload[c];
            endcase
          end
        end
      end
    end
  end

  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || bus_wr) |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/multi_timer_test.sv
`timescale 1ns/1ps
module multi_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #10 clk = ~clk;

  multi_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [31:0] last_rd;

  // behavioural reference state
  logic [31:0] m_count [2];
  logic [31:0] m_reload [2];
  logic [7:0]  m_ctrl [2];
  int          m_phase [2];
  bit          m_done [2];
  logic [1:0]  m_raw, m_mask;

  function automatic logic [31:0] fitm(input logic [31:0] v, input bit w);
    return w ? v : (v & 32'h0000FFFF);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic sel, input logic wr, input logic [5:0] a);
    int g = a[5:4];
    if (!sel || wr || a[1:0] != 0) return 0;
    if (g == 0) begin
      case (a[3:2])
        0: return {30'b0, m_mask};
        1: return {30'b0, m_raw};
        2: return {30'b0, m_raw & m_mask};
        default: return 0;
      endcase
    end
    if (g > 2) return 0;
    case (a[3:2])
      1: return m_count[g-1];
      2: return {24'b0, m_ctrl[g-1]};
      default: return m_reload[g-1];
    endcase
  endfunction

  task automatic m_step(input logic sel, input logic wr, input logic [5:0] a,
                        input logic [31:0] d, input logic tk);
    logic [1:0] exp_bits = 0;
    bit ok = sel && wr && (a[1:0] == 0);
    for (int c = 0; c < 2; c++) begin
      bit en   = m_ctrl[c][7];
      bit os   = m_ctrl[c][0];
      bit wd   = m_ctrl[c][1];
      bit slow = (m_ctrl[c][3:2] != 0);
      bit here = ok && (a[5:4] == c + 1);
      bit ld   = here && (a[3:2] == 0);
      bit sh   = here && (a[3:2] == 3);
      bit cw   = here && (a[3:2] == 2);
      bit fire = 0;
      if (en && !m_done[c] && tk) begin
        if (!slow) fire = 1;
        else if (m_phase[c] == 15) begin fire = 1; m_phase[c] = 0; end
        else m_phase[c]++;
      end
      if (fire) begin
        if (m_count[c] == 1) begin
          exp_bits[c] = 1;
          if (os) begin m_count[c] = 0; m_done[c] = 1; end
          else m_count[c] = fitm(m_reload[c], wd);
        end else m_count[c] = fitm(m_count[c] - 1, wd);
      end
      if (ld) begin
        m_reload[c] = d; m_count[c] = fitm(d, wd); m_done[c] = 0; m_phase[c] = 0;
      end
      if (sh) m_reload[c] = d;
      if (cw) begin
        m_ctrl[c] = d[7:0] & 8'h8F;
        if (!en && d[7]) begin
          m_count[c] = fitm(m_reload[c], d[1]); m_done[c] = 0; m_phase[c] = 0;
        end
      end
    end
    if (ok && a[5:4] == 0 && a[3:2] == 0) m_mask = d[1:0];
    if (ok && a[5:4] == 0 && a[3:2] == 3) m_raw = m_raw & ~d[1:0];
    m_raw = m_raw | exp_bits;
  endtask

  // one clock: drive, compare against model before the edge, then advance model
  task automatic cyc(input logic sel, input logic wr, input logic [5:0] a,
                     input logic [31:0] d, input logic tk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
    #2;
    last_rd = bus_rdata;
    chk(bus_rdata, m_read(sel, wr, a), "R11 per-cycle read data");
    chk({31'b0, irq}, {31'b0, |(m_raw & m_mask)}, "R9 per-cycle irq");
    @(posedge clk);
    @(negedge clk);
    m_step(sel, wr, a, d, tk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 0);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    cyc(1, 0, a, 0, 0);
    chk(last_rd, exp, tag);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    #2;
    chk({31'b0, irq}, {31'b0, exp}, tag);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_count[c] = 0; m_reload[c] = 0; m_ctrl[c] = 0; m_phase[c] = 0; m_done[c] = 0;
    end
    m_raw = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h00, 0, "R1 mask after reset");
    rd(6'h04, 0, "R1 raw after reset");
    rd(6'h14, 0, "R1 count after reset");
    rd(6'h18, 0, "R1 control after reset");
    irq_is(0, "R1 irq after reset");

    // R11 control masking
    wr(6'h18, 32'h7E);
    rd(6'h18, 32'h0E, "R11 control keeps bits 7,3:0");
    wr(6'h18, 32'h02);

    // R2 exact expiry, R5 periodic reload
    wr(6'h10, 5);
    rd(6'h14, 5, "R2 load sets count");
    wr(6'h18, 32'h82);
    run(4);
    rd(6'h04, 0, "R2 no expiry before 5th tick");
    run(1);
    rd(6'h04, 1, "R2 expiry on 5th tick");
    rd(6'h14, 5, "R5 periodic reload");

    // R9 mask
    rd(6'h08, 0, "R9 masked status while masked");
    irq_is(0, "R9 irq low while masked");
    wr(6'h00, 1);
    irq_is(1, "R9 irq high when unmasked");
    rd(6'h08, 1, "R9 masked status");

    // R10 clear
    wr(6'h0C, 2);
    rd(6'h04, 1, "R10 zero bit leaves raw");
    wr(6'h0C, 1);
    rd(6'h04, 0, "R10 clear by one");
    irq_is(0, "R10 irq drops after clear");

    // R5 second reload word
    wr(6'h1C, 3);
    rd(6'h14, 5, "R5 shadow write leaves count");
    rd(6'h1C, 3, "R5 reload value updated");
    run(5);
    rd(6'h14, 3, "R5 next period uses new value");
    rd(6'h04, 1, "R5 expiry with old period");
    wr(6'h0C, 1);

    // R8 disabled
    wr(6'h18, 32'h02);
    run(10);
    rd(6'h14, 3, "R8 count frozen while off");
    rd(6'h04, 0, "R8 no expiry while off");

    // R6 one-shot
    wr(6'h28, 32'h03);
    wr(6'h20, 2);
    wr(6'h28, 32'h83);
    run(2);
    rd(6'h04, 2, "R6 one-shot expiry");
    rd(6'h24, 0, "R6 count at zero");
    run(5);
    rd(6'h24, 0, "R6 holds at zero");
    irq_is(0, "R9 masked channel keeps irq low");
    wr(6'h0C, 2);
    wr(6'h20, 3);
    run(2);
    rd(6'h24, 1, "R6 restart by load");
    run(1);
    rd(6'h04, 2, "R6 expiry after restart");
    wr(6'h0C, 2);
    wr(6'h28, 32'h03);
    wr(6'h28, 32'h83);
    rd(6'h24, 3, "R6 enable edge reloads");

    // R7 divide by 16
    wr(6'h28, 32'h87);
    wr(6'h20, 2);
    run(31);
    rd(6'h04, 0, "R7 no expiry before 32 ticks");
    rd(6'h24, 1, "R7 one step after 16 ticks");
    run(1);
    rd(6'h04, 2, "R7 expiry at 32 ticks");
    wr(6'h0C, 2);

    // R4 narrow mode, R3 zero load
    wr(6'h18, 32'h00);
    wr(6'h10, 32'h12345);
    rd(6'h14, 32'h2345, "R4 narrow load keeps low 16 bits");
    rd(6'h10, 32'h12345, "R4 reload reads full width");
    wr(6'h18, 32'h80);
    wr(6'h10, 0);
    rd(6'h14, 0, "R3 zero load");
    run(1);
    rd(6'h14, 32'hFFFF, "R4 narrow wrap");
    run(65534);
    rd(6'h04, 0, "R3 no expiry before 65536 ticks");
    run(1);
    rd(6'h04, 1, "R3 expiry at 65536 ticks");
    wr(6'h0C, 1);

    // R3 wide wrap
    wr(6'h18, 32'h02);
    wr(6'h10, 0);
    wr(6'h18, 32'h82);
    run(1);
    rd(6'h14, 32'hFFFFFFFF, "R3 wide wrap from zero");
    wr(6'h18, 32'h02);

    // R11 ignored accesses
    wr(6'h14, 7);
    rd(6'h14, 32'hFFFFFFFF, "R11 count write ignored");
    rd(6'h0C, 0, "R11 clear word reads zero");
    rd(6'h15, 0, "R11 unaligned read zero");

    // R10 expiry wins over its clear
    wr(6'h0C, 3);
    wr(6'h28, 32'h83);
    wr(6'h20, 2);
    run(1);
    cyc(1, 1, 6'h0C, 2, 1);
    rd(6'h04, 2, "R10 expiry beats clear");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule